// File: doc/BRIEF.md
# Legacy Replacement Interrupt Router

The router collects interrupt requests from a set of timer channels and two external legacy sources, an interval timer and a real-time clock (RTC), and maps them onto a bank of interrupt output lines. In normal operation every channel is steered by its own 5-bit route field, and the two legacy sources feed fixed lines directly: the interval timer feeds line 0 and the RTC feeds line 8. Each output line is the OR of every source steered to it. All line outputs are registered, so they show the inputs sampled at the previous clock edge.

A legacy-replacement mode bit is held in the block and changes only on a configuration write strobe. While the mode is on, channel 0 takes over line 0 and channel 1 takes over line 8, regardless of their route fields. The external interval-timer and RTC inputs are masked, and an enable output tells the interval timer to stop. Switching the mode has one-update side effects on lines 0 and 8. The RTC level is sampled on every clock edge, so that leaving the mode can restore line 8 to the RTC level recorded before the write.

Top module: `legacy_irq_router`

## Requirements
- R1: While legacy mode is on, a request on channel 0 asserts line 0 and a request on channel 1 asserts line 8 one clock later, whatever their route fields hold.
- R2: Channels 2 and above always go to the line named by their route field (bits [5*i+4:5*i] of ch_route for channel i). Channels 0 and 1 do the same while legacy mode is off. Several sources on one line are ORed.
- R3: While legacy mode is off, pit_irq_i is ORed onto line 0 and rtc_irq_i onto line 8, with one clock of latency. While legacy mode is on, both inputs have no effect on any line.
- R4: The RTC input is sampled on every clock edge, including while legacy mode masks it. On leaving legacy mode, line 8 takes the level sampled at the edge before the write, not the level present during the write.
- R5: A write that turns legacy mode on (cfg_we=1, cfg_legacy=1 while the mode is off) drives lines 0 and 8 low for that update and deasserts pit_en_o.
- R6: A write that turns legacy mode off drives line 0 low for that update, sets line 8 to the sampled RTC level, and reasserts pit_en_o.
- R7: While rst is high and in the cycle after it falls, all lines are low and pit_en_o is high. Reset leaves legacy mode off.
- R8: A route value of NUM_LINES or above (24 to 31 with the defaults) asserts no line.
- R9: The mode changes only when cfg_we is high. A change of cfg_legacy without cfg_we, or a write of the current mode value, causes no side effect on the lines or on pit_en_o.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe for the mode bit |
| cfg_legacy | input | 1 | New legacy-mode value, taken when cfg_we is high |
| ch_req | input | NUM_CH | Per-channel interrupt request levels |
| ch_route | input | NUM_CH*ROUTE_W | Per-channel route fields, channel i at bits [ROUTE_W*i +: ROUTE_W] |
| pit_irq_i | input | 1 | External interval-timer interrupt level |
| rtc_irq_i | input | 1 | External RTC interrupt level |
| irq_o | output | NUM_LINES | Registered interrupt output lines |
| pit_en_o | output | 1 | Interval-timer enable, low while legacy mode is on |

## Verification
The routing function is tried in both modes with single requests, with all channels requesting at once, with a channel sharing line 8 with the RTC path, and with routes past the last line. These patterns tell apart route-field steering, the takeover by channels 0 and 1, the OR merge, and the out-of-range drop. Directed sequences drive the mode edges with the legacy inputs and channel 0 active. These sequences separate the forced transition values from steady routing, and the sampled RTC level from the live input. Redundant writes and strobe-less mode changes show that only true edges cause side effects.

// File: rtl/lirq_pkg.sv
package lirq_pkg;
  localparam int unsigned ROUTE_W_DEF   = 5;
  localparam int unsigned NUM_CH_DEF    = 4;
  localparam int unsigned NUM_LINES_DEF = 24;
  localparam int unsigned PIT_LINE_DEF  = 0;
  localparam int unsigned RTC_LINE_DEF  = 8;

  // Mode information handed from the mode controller to the line stage
  typedef struct packed {
    logic mode_nxt;  // mode value after this cycle's write
    logic enter;     // off -> on edge in this cycle
    logic leave;     // on -> off edge in this cycle
    logic rtc_lvl;   // RTC level sampled at the previous edge
  } mode_evt_t;
endpackage

// File: rtl/lirq_mode_ctrl.sv
module lirq_mode_ctrl
  import lirq_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      cfg_we,
  input  logic      cfg_legacy,
  input  logic      rtc_irq_i,
  output mode_evt_t evt_o,
  output logic      mode_q_o,
  output logic      rtc_lvl_o,
  output logic      pit_en_o
);
  logic mode_q;
  logic rtc_q;
  logic pit_q;

  always_comb begin
    evt_o.enter    = cfg_we &  cfg_legacy & ~mode_q;
    evt_o.leave    = cfg_we & ~cfg_legacy &  mode_q;
    evt_o.mode_nxt = cfg_we ? cfg_legacy : mode_q;
    evt_o.rtc_lvl  = rtc_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= 1'b0;
      rtc_q  <= 1'b0;
      pit_q  <= 1'b1;
    end else begin
      mode_q <= evt_o.mode_nxt;
      rtc_q  <= rtc_irq_i;  // tracked whether masked or not
      if (evt_o.enter)      pit_q <= 1'b0;
      else if (evt_o.leave) pit_q <= 1'b1;
    end
  end

  assign mode_q_o  = mode_q;
  assign rtc_lvl_o = rtc_q;
  assign pit_en_o  = pit_q;
endmodule

// File: rtl/lirq_chan_decode.sv
module lirq_chan_decode #(
  parameter int unsigned NUM_LINES = 24,
  parameter int unsigned ROUTE_W   = 5,
  parameter int unsigned CH_IDX    = 0,
  parameter int unsigned PIT_LINE  = 0,
  parameter int unsigned RTC_LINE  = 8
) (
  input  logic                 req,
  input  logic [ROUTE_W-1:0]   route,
  input  logic                 legacy,
  output logic [NUM_LINES-1:0] hit
);
  logic [ROUTE_W-1:0] eff;

  // Only the first two channels have a legacy takeover line
  if (CH_IDX == 0) begin : g_pit_take
    assign eff = legacy ? ROUTE_W'(PIT_LINE) : route;
  end else if (CH_IDX == 1) begin : g_rtc_take
    assign eff = legacy ? ROUTE_W'(RTC_LINE) : route;
  end else begin : g_plain
    logic unused_legacy;
    assign unused_legacy = legacy;
    assign eff = route;
  end

  // Routes at or beyond NUM_LINES match no line and are dropped
  always_comb begin
    for (int l = 0; l < NUM_LINES; l++) begin
      hit[l] = req && (int'(eff) == l);
    end
  end
endmodule

// File: rtl/lirq_line_out.sv
module lirq_line_out
  import lirq_pkg::*;
#(
  parameter int unsigned NUM_CH    = 4,
  parameter int unsigned NUM_LINES = 24,
  parameter int unsigned PIT_LINE  = 0,
  parameter int unsigned RTC_LINE  = 8
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [NUM_CH*NUM_LINES-1:0] hits,
  input  mode_evt_t                   evt,
  input  logic                        pit_irq_i,
  input  logic                        rtc_irq_i,
  output logic [NUM_LINES-1:0]        irq_o
);
  logic [NUM_LINES-1:0] merged;

  always_comb begin
    merged = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      merged = merged | hits[c*NUM_LINES +: NUM_LINES];
    end
    if (!evt.mode_nxt) begin
      merged[PIT_LINE] = merged[PIT_LINE] | pit_irq_i;
      merged[RTC_LINE] = merged[RTC_LINE] | rtc_irq_i;
    end
    if (evt.enter) begin
      merged[PIT_LINE] = 1'b0;
      merged[RTC_LINE] = 1'b0;
    end
    if (evt.leave) begin
      merged[PIT_LINE] = 1'b0;
      merged[RTC_LINE] = evt.rtc_lvl;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) irq_o <= '0;
    else     irq_o <= merged;
  end
endmodule

// File: rtl/legacy_irq_router.sv
module legacy_irq_router
  import lirq_pkg::*;
#(
  parameter int unsigned NUM_CH    = NUM_CH_DEF,
  parameter int unsigned NUM_LINES = NUM_LINES_DEF,
  parameter int unsigned ROUTE_W   = ROUTE_W_DEF,
  parameter int unsigned PIT_LINE  = PIT_LINE_DEF,
  parameter int unsigned RTC_LINE  = RTC_LINE_DEF
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      cfg_we,
  input  logic                      cfg_legacy,
  input  logic [NUM_CH-1:0]         ch_req,
  input  logic [NUM_CH*ROUTE_W-1:0] ch_route,
  input  logic                      pit_irq_i,
  input  logic                      rtc_irq_i,
  output logic [NUM_LINES-1:0]      irq_o,
  output logic                      pit_en_o
);
  localparam int unsigned HIT_W = NUM_CH * NUM_LINES;

  mode_evt_t        evt;
  logic             mode_q;
  logic             rtc_lvl;
  logic [HIT_W-1:0] hits;

  lirq_mode_ctrl u_mode (
    .clk        (clk),
    .rst        (rst),
    .cfg_we     (cfg_we),
    .cfg_legacy (cfg_legacy),
    .rtc_irq_i  (rtc_irq_i),
    .evt_o      (evt),
    .mode_q_o   (mode_q),
    .rtc_lvl_o  (rtc_lvl),
    .pit_en_o   (pit_en_o)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    lirq_chan_decode #(
      .NUM_LINES (NUM_LINES),
      .ROUTE_W   (ROUTE_W),
      .CH_IDX    (c),
      .PIT_LINE  (PIT_LINE),
      .RTC_LINE  (RTC_LINE)
    ) u_dec (
      .req    (ch_req[c]),
      .route  (ch_route[c*ROUTE_W +: ROUTE_W]),
      .legacy (evt.mode_nxt),
      .hit    (hits[c*NUM_LINES +: NUM_LINES])
    );
  end

  lirq_line_out #(
    .NUM_CH    (NUM_CH),
    .NUM_LINES (NUM_LINES),
    .PIT_LINE  (PIT_LINE),
    .RTC_LINE  (RTC_LINE)
  ) u_lines (
    .clk       (clk),
    .rst       (rst),
    .hits      (hits),
    .evt       (evt),
    .pit_irq_i (pit_irq_i),
    .rtc_irq_i (rtc_irq_i),
    .irq_o     (irq_o)
  );
endmodule

// File: rtl/lirq_checker.sv
module lirq_checker #(
  parameter int unsigned NUM_LINES = 24,
  parameter int unsigned PIT_LINE  = 0,
  parameter int unsigned RTC_LINE  = 8
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 cfg_we,
  input logic                 cfg_legacy,
  input logic                 ch0_req,
  input logic                 pit_irq_i,
  input logic [NUM_LINES-1:0] irq_o,
  input logic                 pit_en_o,
  input logic                 mode_q,
  input logic                 rtc_lvl
);
  logic rst_d;
  always_ff @(posedge clk) rst_d <= rst;

  AST_RESET_STATE: assert property (@(posedge clk) disable iff (rst)
    rst_d |-> (pit_en_o && irq_o == '0)); // R7

  AST_LEGACY_CH0: assert property (@(posedge clk) disable iff (rst)
    (mode_q && !(cfg_we && !cfg_legacy) && ch0_req) |=> irq_o[PIT_LINE]); // R1

  AST_PIT_PASS: assert property (@(posedge clk) disable iff (rst)
    (!mode_q && !(cfg_we && cfg_legacy) && pit_irq_i) |=> irq_o[PIT_LINE]); // R3

  AST_ENTER_MASK: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && cfg_legacy && !mode_q) |=>
      (!irq_o[PIT_LINE] && !irq_o[RTC_LINE] && !pit_en_o)); // R5

  AST_LEAVE_RESTORE: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && !cfg_legacy && mode_q) |=>
      (!irq_o[PIT_LINE] && pit_en_o && irq_o[RTC_LINE] == $past(rtc_lvl))); // R6

  AST_PIT_EN_HOLD: assert property (@(posedge clk) disable iff (rst)
    !cfg_we |=> $stable(pit_en_o)); // R9
endmodule

bind legacy_irq_router lirq_checker #(
  .NUM_LINES (NUM_LINES),
  .PIT_LINE  (PIT_LINE),
  .RTC_LINE  (RTC_LINE)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .cfg_we     (cfg_we),
  .cfg_legacy (cfg_legacy),
  .ch0_req    (ch_req[0]),
  .pit_irq_i  (pit_irq_i),
  .irq_o      (irq_o),
  .pit_en_o   (pit_en_o),
  .mode_q     (mode_q),
  .rtc_lvl    (rtc_lvl)
);

// File: tb/legacy_irq_router_tb_top.sv
`timescale 1ns/1ps
module legacy_irq_router_tb_top;
  localparam int NCH = 4;
  localparam int NLN = 24;
  localparam int RW  = 5;

  logic            clk = 1'b0;
  logic            rst;
  logic            cfg_we, cfg_legacy;
  logic [NCH-1:0]  ch_req;
  logic [NCH*RW-1:0] ch_route;
  logic            pit_irq_i, rtc_irq_i;
  logic [NLN-1:0]  irq_o;
  logic            pit_en_o;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  always #2 clk = ~clk;

  legacy_irq_router #(.NUM_CH(NCH), .NUM_LINES(NLN), .ROUTE_W(RW)) dut_i (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_legacy(cfg_legacy),
    .ch_req(ch_req), .ch_route(ch_route), .pit_irq_i(pit_irq_i),
    .rtc_irq_i(rtc_irq_i), .irq_o(irq_o), .pit_en_o(pit_en_o)
  );

  typedef struct packed {
    logic [3:0]  tag;     // requirement number
    logic        mode;
    logic [3:0]  req;
    logic [19:0] routes;  // {r3, r2, r1, r0}
    logic        pit;
    logic        rtc;
    logic [23:0] exp;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{4'd2, 1'b0, 4'b0001, {5'd9, 5'd7, 5'd6, 5'd5}, 1'b0, 1'b0, 24'h000020}, // R2 single
    '{4'd2, 1'b0, 4'b1111, {5'd9, 5'd7, 5'd6, 5'd5}, 1'b0, 1'b0, 24'h0002E0}, // R2 all
    '{4'd3, 1'b0, 4'b0000, {5'd9, 5'd7, 5'd6, 5'd5}, 1'b1, 1'b1, 24'h000101}, // R3 pass
    '{4'd2, 1'b0, 4'b0100, {5'd9, 5'd8, 5'd6, 5'd5}, 1'b0, 1'b1, 24'h000100}, // R2 share 8
    '{4'd8, 1'b0, 4'b1000, {5'd30, 5'd7, 5'd6, 5'd5}, 1'b0, 1'b0, 24'h000000}, // R8
    '{4'd1, 1'b1, 4'b0011, {5'd9, 5'd7, 5'd6, 5'd5}, 1'b0, 1'b0, 24'h000101}, // R1
    '{4'd1, 1'b1, 4'b1100, {5'd9, 5'd7, 5'd6, 5'd5}, 1'b1, 1'b1, 24'h000280}, // R1 R3 mask
    '{4'd3, 1'b1, 4'b0000, {5'd9, 5'd7, 5'd6, 5'd5}, 1'b1, 1'b1, 24'h000000}, // R3 masked
    '{4'd1, 1'b1, 4'b0001, {5'd9, 5'd7, 5'd6, 5'd23}, 1'b0, 1'b0, 24'h000001}, // R1 ignore route
    '{4'd2, 1'b1, 4'b0100, {5'd9, 5'd0, 5'd6, 5'd5}, 1'b0, 1'b0, 24'h000001}, // R2 in legacy
    '{4'd8, 1'b1, 4'b1000, {5'd24, 5'd7, 5'd6, 5'd5}, 1'b0, 1'b0, 24'h000000}  // R8 legacy
  };

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic set_mode(input logic m);
    cfg_we = 1'b1; cfg_legacy = m;
    tick();
    cfg_we = 1'b0;
    tick();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    logic cur_mode;
    rst = 1'b1; cfg_we = 1'b0; cfg_legacy = 1'b0; ch_req = '0; ch_route = '0;
    pit_irq_i = 1'b0; rtc_irq_i = 1'b0;
    repeat (3) tick();
    chk("R7 lines in reset", 32'(irq_o), 32'h0);
    chk("R7 pit_en in reset", 32'(pit_en_o), 32'h1);
    rst = 1'b0;
    tick();
    chk("R7 lines after reset", 32'(irq_o), 32'h0);
    chk("R7 pit_en after reset", 32'(pit_en_o), 32'h1);

    // Table walk
    cur_mode = 1'b0;
    for (int i = 0; i < NV; i++) begin
      if (VECS[i].mode != cur_mode) begin
        set_mode(VECS[i].mode);
        cur_mode = VECS[i].mode;
      end
      ch_req = VECS[i].req; ch_route = VECS[i].routes;
      pit_irq_i = VECS[i].pit; rtc_irq_i = VECS[i].rtc;
      tick();
      chk($sformatf("R%0d vector %0d", VECS[i].tag, i), 32'(irq_o), 32'(VECS[i].exp));
    end

    // Directed: entering legacy mode
    set_mode(1'b0);
    ch_req = 4'b0001; ch_route = {5'd9, 5'd7, 5'd6, 5'd3};
    pit_irq_i = 1'b1; rtc_irq_i = 1'b1;
    tick();
    chk("R3 normal with ch0 on 3", 32'(irq_o), 32'h109);
    cfg_we = 1'b1; cfg_legacy = 1'b1;
    tick();
    chk("R5 enter lines", 32'(irq_o), 32'h0);
    chk("R5 enter pit_en", 32'(pit_en_o), 32'h0);
    cfg_we = 1'b0;
    tick();
    chk("R1 ch0 takes line 0", 32'(irq_o), 32'h1);

    // Redundant write and strobe-less change
    cfg_we = 1'b1; cfg_legacy = 1'b1;
    tick();
    chk("R9 redundant write lines", 32'(irq_o), 32'h1);
    chk("R9 redundant write pit_en", 32'(pit_en_o), 32'h0);
    cfg_we = 1'b0; cfg_legacy = 1'b0;
    tick();
    chk("R9 no strobe lines", 32'(irq_o), 32'h1);
    chk("R9 no strobe pit_en", 32'(pit_en_o), 32'h0);

    // Leaving: RTC sampled 1, live input 0 during the write
    ch_req = '0; rtc_irq_i = 1'b0; pit_irq_i = 1'b1;
    cfg_we = 1'b1; cfg_legacy = 1'b0;
    tick();
    chk("R6 R4 leave restores latched RTC", 32'(irq_o), 32'h100);
    chk("R6 leave pit_en", 32'(pit_en_o), 32'h1);
    cfg_we = 1'b0;
    tick();
    chk("R3 after leave", 32'(irq_o), 32'h1);

    // Latch follows a masked RTC pulse
    pit_irq_i = 1'b0;
    set_mode(1'b1);
    rtc_irq_i = 1'b1;
    tick();
    chk("R3 RTC masked in legacy", 32'(irq_o), 32'h0);
    rtc_irq_i = 1'b0;
    tick();
    rtc_irq_i = 1'b1;
    cfg_we = 1'b1; cfg_legacy = 1'b0;
    tick();
    chk("R4 leave uses sampled low level", 32'(irq_o), 32'h0);
    cfg_we = 1'b0;
    tick();
    chk("R3 live RTC after leave", 32'(irq_o), 32'h100);

    // Reset while in legacy mode
    set_mode(1'b1);
    chk("R5 pit_en low in legacy", 32'(pit_en_o), 32'h0);
    rst = 1'b1;
    tick();
    rst = 1'b0;
    chk("R7 reset restores pit_en", 32'(pit_en_o), 32'h1);
    pit_irq_i = 1'b1; rtc_irq_i = 1'b0;
    tick();
    tick();
    chk("R7 reset leaves mode off", 32'(irq_o), 32'h1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule